// File: doc/BRIEF.md
# Two-Level Page Table Walker

The block translates a 32-bit virtual address into a physical address by walking a two-level page table in memory. Pages are 4 KB, so the low 12 bits of the address are the page offset and go through without change. The upper 20 bits are split into two 10-bit indices. The upper index selects a 4-byte entry in the root table. That entry, if valid, names the frame that holds a second-level table. The lower index then selects a 4-byte entry in that table. Each table has 1024 entries.

A walk starts when a request is accepted. The root table's frame number is taken from an input driven by a register elsewhere, and is sampled at that moment. The walker issues one dependent read per level over a single read port. That port has a request handshake and a response strobe, and the response may come after any number of cycles. The walk ends with the physical address, or with a fault that also says which level held the invalid entry. The result is held until it is taken, and only then can a new request be accepted.

Top module: `pgw_walker`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 while `mem_rd_valid` and `res_valid` are 0, even if the reset arrives mid-walk.
- R2: The first read of a walk uses the address `{root_frame, 12'h000} + 4 * vaddr[31:22]`, with `root_frame` taken from the cycle in which the request was accepted.
- R3: When the first-level entry has bit 0 set, a second read follows at `{entry[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R4: When the first-level entry has bit 0 clear, no second read is issued. The result then has `res_fault`=1, `res_fault_l2`=0 and `res_paddr`=0.
- R5: When the second-level entry has bit 0 clear, the result has `res_fault`=1, `res_fault_l2`=1 and `res_paddr`=0.
- R6: When the second-level entry has bit 0 set, the result has `res_fault`=0 and `res_paddr` = `{entry[31:12], vaddr[11:0]}`.
- R7: Once `mem_rd_valid` is raised, it stays high with an unchanged `mem_rd_addr` until a cycle in which `mem_rd_ready` is 1.
- R8: A response is accepted either in the same cycle as the read's acceptance or in any later cycle, with any number of wait cycles in between.
- R9: At most one of `req_ready`, `mem_rd_valid` and `res_valid` is high. The result stays valid and unchanged until `res_ready` is 1. Requests presented while a walk or result is pending are ignored.
- R10: Changes to `root_frame` or `req_vaddr` after a request is accepted do not affect that walk.
- R11: A response strobe that arrives when no read is outstanding is ignored and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_frame | input | 20 | Frame number of the first-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_rd_valid | output | 1 | Entry read requested |
| mem_rd_ready | input | 1 | Memory accepts the read this cycle |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry value: bit 0 valid, bits 31:12 frame number |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | 32 | Translated physical address, 0 on a fault |
| res_fault | output | 1 | The walk hit an invalid entry |
| res_fault_l2 | output | 1 | The invalid entry was at the second level |

## Verification
The bench varies how long the memory holds off a read and how long the response takes. The cases run from a response in the same cycle as the grant to one that takes forty cycles. A walker that decodes the response only in its wait state would hang or read a stale entry in the same-cycle case. One that drops its request early would give up the read during a hold-off. Invalid entries at each level check that a first-level fault issues no second read and that the two levels are told apart. A walker that continued past an invalid entry would place an unexpected read, and a swapped level flag would show in the result. The bench also changes the root frame and address inputs mid-walk, sends responses while idle, applies reset in the middle of a wait, and presents requests while a result is pending. A design that failed to latch its inputs, or that let any of these events through, would produce wrong addresses or a phantom walk.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int VA_W       = 32;
    localparam int PA_W       = 32;
    localparam int OFF_W      = 12;
    localparam int IDX_W      = 10;
    localparam int PTE_W      = 32;
    localparam int LEVELS     = 2;
    localparam int ENT_SHIFT  = 2;
    localparam int FRAME_W    = PA_W - OFF_W;
    localparam int PTE_RSVD_W = PTE_W - FRAME_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0]    frame;
        logic [PTE_RSVD_W-1:0] rsvd;
        logic                  valid;
    } pte_t;

    typedef struct packed {
        logic [PA_W-1:0] paddr;
        logic            fault;
        logic            fault_l2;
    } walk_result_t;

    // Index field of a given level (0 = root) inside the virtual address.
    function automatic logic [IDX_W-1:0] level_index(input logic [VA_W-1:0] va,
                                                     input int unsigned   lvl);
        return va[OFF_W + IDX_W*(LEVELS - int'(lvl)) - 1 -: IDX_W];
    endfunction

    // Byte address of an entry: table frame base plus index scaled by entry size.
    function automatic logic [PA_W-1:0] entry_address(input logic [FRAME_W-1:0] frame,
                                                      input logic [IDX_W-1:0]   idx);
        logic [PA_W-1:0] base;
        logic [PA_W-1:0] scaled;
        base   = {frame, {OFF_W{1'b0}}};
        scaled = PA_W'({idx, {ENT_SHIFT{1'b0}}});
        return base + scaled;
    endfunction

endpackage

// File: rtl/pgw_fsm.sv
module pgw_fsm
    import pgw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        mem_rd_ready,
    input  logic        mem_rsp_valid,
    input  logic        pte_valid,
    input  logic        res_ready,
    output walk_state_e state,
    output logic        accept,
    output logic        rsp_take,
    output logic        level2
);

    walk_state_e state_q, state_d;

    logic in_req;
    logic in_wait;

    assign in_req   = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
    assign in_wait  = (state_q == ST_L1_WAIT) || (state_q == ST_L2_WAIT);
    assign level2   = (state_q == ST_L2_REQ) || (state_q == ST_L2_WAIT);
    assign accept   = (state_q == ST_IDLE) && req_valid;
    // A response counts while waiting, or in the very cycle the read is granted.
    assign rsp_take = mem_rsp_valid && (in_wait || (in_req && mem_rd_ready));
    assign state    = state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_L1_REQ;
            end
            ST_L1_REQ, ST_L1_WAIT: begin
                if (rsp_take)
                    state_d = pte_valid ? ST_L2_REQ : ST_DONE;
                else if (state_q == ST_L1_REQ && mem_rd_ready)
                    state_d = ST_L1_WAIT;
            end
            ST_L2_REQ, ST_L2_WAIT: begin
                if (rsp_take)
                    state_d = ST_DONE;
                else if (state_q == ST_L2_REQ && mem_rd_ready)
                    state_d = ST_L2_WAIT;
            end
            ST_DONE: begin
                if (res_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/pgw_addr.sv
module pgw_addr
    import pgw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic               advance,
    input  logic [FRAME_W-1:0] next_frame,
    input  logic               level2,
    output logic [OFF_W-1:0]   page_off,
    output logic [PA_W-1:0]    rd_addr
);

    logic [VA_W-1:0]    vaddr_q;
    logic [FRAME_W-1:0] frame_q;
    logic [IDX_W-1:0]   idx_sel [LEVELS];

    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_idx
            assign idx_sel[g] = level_index(vaddr_q, g);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            vaddr_q <= '0;
            frame_q <= '0;
        end else if (accept) begin
            vaddr_q <= req_vaddr;
            frame_q <= root_frame;
        end else if (advance) begin
            frame_q <= next_frame;
        end
    end

    assign rd_addr  = entry_address(frame_q, level2 ? idx_sel[1] : idx_sel[0]);
    assign page_off = vaddr_q[OFF_W-1:0];

endmodule

// File: rtl/pgw_result.sv
module pgw_result
    import pgw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rsp_take,
    input  logic               level2,
    input  logic               pte_valid,
    input  logic [FRAME_W-1:0] pte_frame,
    input  logic [OFF_W-1:0]   page_off,
    output walk_result_t       result
);

    walk_result_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (rsp_take) begin
            if (!pte_valid) begin
                res_q.paddr    <= '0;
                res_q.fault    <= 1'b1;
                res_q.fault_l2 <= level2;
            end else if (level2) begin
                res_q.paddr    <= {pte_frame, page_off};
                res_q.fault    <= 1'b0;
                res_q.fault_l2 <= 1'b0;
            end
        end
    end

    assign result = res_q;

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
    import pgw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [FRAME_W-1:0]  root_frame,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    output logic                mem_rd_valid,
    input  logic                mem_rd_ready,
    output logic [PA_W-1:0]     mem_rd_addr,
    input  logic                mem_rsp_valid,
    input  logic [PTE_W-1:0]    mem_rsp_data,
    output logic                res_valid,
    input  logic                res_ready,
    output logic [PA_W-1:0]     res_paddr,
    output logic                res_fault,
    output logic                res_fault_l2
);

    walk_state_e  state;
    logic         accept;
    logic         rsp_take;
    logic         level2;
    logic [OFF_W-1:0] page_off;
    pte_t         pte;
    walk_result_t result;

    assign pte = pte_t'(mem_rsp_data);

    pgw_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .pte_valid     (pte.valid),
        .res_ready     (res_ready),
        .state         (state),
        .accept        (accept),
        .rsp_take      (rsp_take),
        .level2        (level2)
    );

    pgw_addr u_addr (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req_vaddr  (req_vaddr),
        .root_frame (root_frame),
        .advance    (rsp_take && !level2 && pte.valid),
        .next_frame (pte.frame),
        .level2     (level2),
        .page_off   (page_off),
        .rd_addr    (mem_rd_addr)
    );

    pgw_result u_result (
        .clk       (clk),
        .rst       (rst),
        .rsp_take  (rsp_take),
        .level2    (level2),
        .pte_valid (pte.valid),
        .pte_frame (pte.frame),
        .page_off  (page_off),
        .result    (result)
    );

    assign req_ready    = (state == ST_IDLE);
    assign mem_rd_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
    assign res_valid    = (state == ST_DONE);
    assign res_paddr    = result.paddr;
    assign res_fault    = result.fault;
    assign res_fault_l2 = result.fault_l2;

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker
    import pgw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             mem_rd_valid,
    input logic             mem_rd_ready,
    input logic [PA_W-1:0]  mem_rd_addr,
    input logic             res_valid,
    input logic             res_ready,
    input logic [PA_W-1:0]  res_paddr,
    input logic             res_fault,
    input logic             res_fault_l2
);

    // R1: reset always returns to the idle handshake state
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (req_ready && !mem_rd_valid && !res_valid));

    // R7: a pending read keeps its address until granted
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R9: phases are mutually exclusive
    p_phase_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_ready, mem_rd_valid, res_valid}));

    // R9: result held until taken
    p_res_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr)
                                       && $stable(res_fault) && $stable(res_fault_l2)));

    // R4 / R5: a faulted result carries a zero address
    p_fault_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fault) |-> (res_paddr == '0));

    // R5: the level flag is only meaningful with a fault
    p_lvl_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fault_l2) |-> res_fault);

endmodule

bind pgw_walker pgw_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .res_valid    (res_valid),
    .res_ready    (res_ready),
    .res_paddr    (res_paddr),
    .res_fault    (res_fault),
    .res_fault_l2 (res_fault_l2)
);

// File: tb/tb_pgw_walker.sv
`timescale 1ns/1ps
module tb_pgw_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] root_frame = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [31:0] res_paddr;
    logic        res_fault;
    logic        res_fault_l2;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    pgw_walker dut (.*);

    // Stimulus and expected-result table
    localparam int NV = 7;
    localparam logic [31:0] V_VA  [NV] = '{32'h0040_1234, 32'hFFFF_FFFF, 32'h0000_0000,
                                           32'h8020_3ABC, 32'h1234_5678, 32'h003F_F000,
                                           32'h0C84_2ABC};
    localparam logic [19:0] V_RT  [NV] = '{20'h00100, 20'h7FFFF, 20'h00000,
                                           20'h00AB0, 20'h11111, 20'h00001, 20'h0F00F};
    localparam logic [31:0] V_L1  [NV] = '{32'h0020_0001, 32'h1234_5001, 32'h0000_0000,
                                           32'h00CC_0FFE, 32'h2222_2001, 32'h0000_2001,
                                           32'h4444_4001};
    localparam logic [31:0] V_L2  [NV] = '{32'hABCD_E003, 32'h0F0F_0FFF, 32'h0,
                                           32'h0, 32'h3333_3FFE, 32'hFFFF_F001,
                                           32'h5555_5001};
    localparam int          V_GNT [NV] = '{0, 2, 0, 1, 3, 0, 1};
    localparam int          V_LAT [NV] = '{0, 3, 5, 0, 1, 0, 40};
    localparam logic [31:0] E_PA  [NV] = '{32'hABCD_E234, 32'h0F0F_0FFF, 32'h0,
                                           32'h0, 32'h0, 32'hFFFF_F000, 32'h5555_5ABC};
    localparam logic        E_F   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic        E_F2  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    // Serve one entry read: hold-off of gnt cycles, response lat cycles after grant.
    task automatic serve(input logic [31:0] exp_addr, input logic [31:0] data,
                         input int gnt, input int lat, input string tag);
        int t = 0;
        while (!mem_rd_valid && t < 60) begin
            @(negedge clk);
            t++;
        end
        chk(mem_rd_valid, {tag, " read issued"}, 32'(mem_rd_valid), 32'h1);
        chk(mem_rd_addr == exp_addr, {tag, " entry address"}, mem_rd_addr, exp_addr);
        for (int k = 0; k < gnt; k++) begin
            @(negedge clk);
            chk(mem_rd_valid && mem_rd_addr == exp_addr, "R7 read held until granted",
                mem_rd_addr, exp_addr);
        end
        mem_rd_ready = 1'b1;
        if (lat == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = data;
        end
        @(negedge clk);
        mem_rd_ready  = 1'b0;
        mem_rsp_valid = 1'b0;
        if (lat > 0) begin
            mem_rsp_data = 32'hFFFF_FFFF;
            repeat (lat - 1) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = data;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end
        mem_rsp_data = 32'hFFFF_FFFF;
    endtask

    task automatic run_vec(input int i);
        logic [31:0] va;
        logic [19:0] rt;
        logic [31:0] a1;
        logic [31:0] a2;
        va = V_VA[i];
        rt = V_RT[i];
        a1 = {rt, 12'h000} + {20'h0, va[31:22], 2'b00};
        a2 = {V_L1[i][31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
        @(negedge clk);
        chk(req_ready, "R9 idle before request", 32'(req_ready), 32'h1);
        req_valid = 1'b1;
        req_vaddr = va;
        root_frame = rt;
        @(negedge clk);
        req_valid  = 1'b0;
        req_vaddr  = ~va;   // R10: late changes must not matter
        root_frame = ~rt;
        serve(a1, V_L1[i], V_GNT[i], V_LAT[i], "R2");
        if (V_L1[i][0]) serve(a2, V_L2[i], V_GNT[i], V_LAT[i], "R3");
        else chk(!mem_rd_valid, "R4 no second read", 32'(mem_rd_valid), 32'h0);
        chk(res_valid, "R8 result after response", 32'(res_valid), 32'h1);
        chk(res_paddr == E_PA[i], "R6 physical address", res_paddr, E_PA[i]);
        chk(res_fault == E_F[i], "R4 fault flag", 32'(res_fault), 32'(E_F[i]));
        chk(res_fault_l2 == E_F2[i], "R5 fault level", 32'(res_fault_l2), 32'(E_F2[i]));
        req_valid = 1'b1;   // R9: ignored while result pending
        req_vaddr = 32'h1111_1111;
        @(negedge clk);
        chk(res_valid && !req_ready && res_paddr == E_PA[i], "R9 result held",
            res_paddr, E_PA[i]);
        req_valid = 1'b0;
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk(req_ready && !mem_rd_valid && !res_valid, "R9 back to idle, no phantom walk",
            {29'h0, req_ready, mem_rd_valid, res_valid}, 32'h4);
    endtask

    initial begin
        mem_rsp_data = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !mem_rd_valid && !res_valid, "R1 reset state",
            {29'h0, req_ready, mem_rd_valid, res_valid}, 32'h4);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R11: stray responses while idle
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'h7777_7001;
        repeat (3) @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(req_ready && !mem_rd_valid && !res_valid, "R11 stray response ignored",
            {29'h0, req_ready, mem_rd_valid, res_valid}, 32'h4);
        run_vec(0);

        // R1: reset in the middle of a wait
        req_valid  = 1'b1;
        req_vaddr  = 32'h0040_1234;
        root_frame = 20'h00100;
        @(negedge clk);
        req_valid    = 1'b0;
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(req_ready && !mem_rd_valid && !res_valid, "R1 reset mid-walk",
            {29'h0, req_ready, mem_rd_valid, res_valid}, 32'h4);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'h0020_0001;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(req_ready && !mem_rd_valid && !res_valid, "R11 late response after reset",
            {29'h0, req_ready, mem_rd_valid, res_valid}, 32'h4);
        run_vec(4);

        finish_run();
    end

endmodule